// File: doc/BRIEF.md
# ADC conversion timing sequencer

This block is the digital timing core that sits beside a successive-approximation converter. It divides the system clock down to a converter clock, counts the converter cycles of each conversion, and emits the strobes that tell the analog side when to sample and when the result is ready to be captured. The comparator, the DAC and the result register are not part of it. Its inputs come from control-register bits, and a result-capture stage sits downstream of the write strobe.

A conversion can be launched in three ways. Software can request one conversion. Software can start an endless chain of back-to-back conversions. A rising edge on an external trigger line can launch a conversion, and that edge realigns the clock divider so the delay from trigger to sample is always the same. The first conversion after the block is enabled is longer, because the analog front end needs time to settle, and its sample point comes later.

All timing below is counted in system clock cycles. D is the division ratio chosen by `prescale_sel`. The start of a conversion is the converter-clock tick at which its first converter cycle begins.

Top module: `adc_conv_seq`

## Requirements
- R1: While `en` is low, the divider is held at zero and `adc_clk_en`, `sample_stb` and `result_wr` stay low. `start_bit` is cleared. The first conversion after `en` rises is a long one (R5). Out of reset all outputs are low.
- R2: `adc_clk_en` is a one-cycle tick every D cycles. D is 2 for select 0 and 2^s for select s = 1..7.
- R3: A start request (`start_req` high for one cycle while idle) makes `start_bit` read 1 from the next cycle. The conversion starts at the next `adc_clk_en` tick, no more than D cycles later.
- R4: An ordinary conversion pulses `sample_stb` 1.5·D cycles after its start and pulses `result_wr` 13·D cycles after its start.
- R5: The first conversion after enable pulses `sample_stb` 13.5·D cycles after its start and `result_wr` 25·D cycles after its start.
- R6: `result_wr` is a one-cycle pulse that coincides with an `adc_clk_en` tick. `irq_flag` reads 1 from the next cycle. Outside free-running mode, `start_bit` reads 0 from that same next cycle.
- R7: `irq_flag` stays set until `flag_clr` is high for a cycle. If completion and clear fall in the same cycle, the flag is set.
- R8: A start request that arrives while a conversion is running is ignored. No extra conversion follows, and `start_bit` still clears at completion.
- R9: With `mode` = 1 (free running), each completion starts the next conversion at once. Completions are 13·D cycles apart after the long first one, and `start_bit` stays 1.
- R10: With `mode` = 2 (trigger), a trigger input first seen high in cycle T restarts the divider and launches a conversion. Its sample strobe comes in cycle T + 2 + 1.5·D, or T + 2 + 13.5·D for the first conversion after enable. Mode 0, and the spare code 3, are single conversion.
- R11: A trigger edge that arrives while a conversion is running has no effect. It neither moves the divider nor changes the completion time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Converter enable; low holds the divider in reset |
| start_req | input | 1 | One-cycle write of 1 to the start bit |
| mode | input | 2 | 0 single, 1 free running, 2 external trigger, 3 treated as single |
| prescale_sel | input | 3 | Divider select: D = 2 for 0, else 2^sel |
| trig_in | input | 1 | Asynchronous trigger source |
| flag_clr | input | 1 | One-cycle clear of the completion flag |
| adc_clk_en | output | 1 | Converter clock rising-edge tick |
| sample_stb | output | 1 | Sample-and-hold strobe at a mid-cycle point |
| result_wr | output | 1 | Result capture strobe at end of conversion |
| irq_flag | output | 1 | Sticky completion flag |
| start_bit | output | 1 | Read-back of the start bit |

## Verification
The bench uses the default parameters: 3 select bits, 13 and 25 cycle conversions, sample indices 1 and 13, and a two-stage rising-edge trigger synchroniser. With a 3-bit select, all eight division ratios fit in one run, including the 128 ratio that makes a first conversion last 3200 cycles. Every sample and completion time is measured against D for each ratio. The trigger tests run at ratios 2 and 8, with the trigger landing at different phases of the divider, so they show that the trigger-to-sample delay does not depend on phase.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [1:0] {
      MODE_ONE  = 2'd0,
      MODE_FREE = 2'd1,
      MODE_TRIG = 2'd2,
      MODE_SPARE = 2'd3
   } conv_mode_e;

   // Division ratio for a select code: code 0 aliases code 1.
   function automatic int unsigned div_of(input int unsigned code);
      return (code == 0) ? 2 : (32'd1 << code);
   endfunction

endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler
   import adc_seq_pkg::*;
#(
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             restart,
   input  logic [SEL_W-1:0] sel,
   output logic             rise,
   output logic             fall
);
   localparam int MAX_DIV = 1 << ((1 << SEL_W) - 1);
   localparam int PC_W    = $clog2(MAX_DIV);

   logic [PC_W-1:0] pc;
   logic [PC_W-1:0] lim;
   logic [PC_W-1:0] half;

   always_comb begin
      lim  = PC_W'(div_of(int'(sel)) - 1);
      half = PC_W'(div_of(int'(sel)) / 2 - 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pc <= '0;
      else if (!en || restart)   pc <= '0;
      else if (pc >= lim)        pc <= '0;
      else                       pc <= pc + 1'b1;
   end

   assign rise = en && (pc >= lim);
   assign fall = en && (pc == half);

endmodule

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
   parameter int STAGES = 2,
   parameter bit RISING = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic edge_seen
);
   logic [STAGES-1:0] sync_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], raw};
         last_q <= sync_q[STAGES-1];
      end
   end

   generate
      if (RISING) begin : g_rise
         assign edge_seen = sync_q[STAGES-1] & ~last_q;
      end else begin : g_fall
         assign edge_seen = ~sync_q[STAGES-1] & last_q;
      end
   endgenerate

endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
   import adc_seq_pkg::*;
#(
   parameter int NORM_LEN  = 13,
   parameter int FIRST_LEN = 25,
   parameter int NORM_SH   = 1,
   parameter int FIRST_SH  = 13
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       start_req,
   input  conv_mode_e mode,
   input  logic       rise,
   input  logic       fall,
   input  logic       trig_edge,
   input  logic       flag_clr,
   output logic       restart,
   output logic       sample_stb,
   output logic       result_wr,
   output logic       irq_flag,
   output logic       start_bit
);
   localparam int CC_W = $clog2(FIRST_LEN);
   localparam logic [CC_W-1:0] NORM_LAST  = CC_W'(NORM_LEN - 1);
   localparam logic [CC_W-1:0] FIRST_LAST = CC_W'(FIRST_LEN - 1);
   localparam logic [CC_W-1:0] NORM_SIDX  = CC_W'(NORM_SH);
   localparam logic [CC_W-1:0] FIRST_SIDX = CC_W'(FIRST_SH);

   logic            busy, first_q, sb_q, flag_q;
   logic [CC_W-1:0] cnt;
   logic [CC_W-1:0] last_idx, samp_idx;
   logic            trig_go, sw_go, go, done;

   always_comb begin
      last_idx = first_q ? FIRST_LAST : NORM_LAST;
      samp_idx = first_q ? FIRST_SIDX : NORM_SIDX;
      trig_go  = en && (mode == MODE_TRIG) && trig_edge && !busy;
      sw_go    = en && rise && sb_q && !busy;
      go       = trig_go || sw_go;
      done     = busy && rise && (cnt == last_idx);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         cnt     <= '0;
         sb_q    <= 1'b0;
         first_q <= 1'b1;
         flag_q  <= 1'b0;
      end else begin
         if (done)          flag_q <= 1'b1;
         else if (flag_clr) flag_q <= 1'b0;

         if (!en) begin
            busy    <= 1'b0;
            cnt     <= '0;
            sb_q    <= 1'b0;
            first_q <= 1'b1;
         end else begin
            if (start_req && !busy) sb_q <= 1'b1;
            if (go) begin
               busy <= 1'b1;
               cnt  <= '0;
            end else if (done) begin
               cnt     <= '0;
               first_q <= 1'b0;
               if (mode != MODE_FREE) begin
                  busy <= 1'b0;
                  sb_q <= 1'b0;
               end
            end else if (busy && rise) begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   assign restart    = trig_go;
   assign sample_stb = busy && fall && (cnt == samp_idx);
   assign result_wr  = done;
   assign irq_flag   = flag_q;
   assign start_bit  = sb_q;

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
   import adc_seq_pkg::*;
#(
   parameter int SEL_W       = 3,
   parameter int NORM_LEN    = 13,
   parameter int FIRST_LEN   = 25,
   parameter int NORM_SH     = 1,
   parameter int FIRST_SH    = 13,
   parameter int SYNC_STAGES = 2,
   parameter bit TRIG_RISING = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             start_req,
   input  logic [1:0]       mode,
   input  logic [SEL_W-1:0] prescale_sel,
   input  logic             trig_in,
   input  logic             flag_clr,
   output logic             adc_clk_en,
   output logic             sample_stb,
   output logic             result_wr,
   output logic             irq_flag,
   output logic             start_bit
);
   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("SEL_W must lie in 1..4");
   end
   if (FIRST_LEN <= NORM_LEN || NORM_LEN < 2) begin : g_bad_len
      $error("FIRST_LEN must exceed NORM_LEN, NORM_LEN at least 2");
   end
   if (NORM_SH >= NORM_LEN - 1 || FIRST_SH >= FIRST_LEN - 1) begin : g_bad_sh
      $error("sample index must precede the last conversion cycle");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic rise, fall, restart, trig_edge;

   adc_prescaler #(.SEL_W(SEL_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en),
      .restart (restart),
      .sel     (prescale_sel),
      .rise    (rise),
      .fall    (fall)
   );

   adc_trig_sync #(.STAGES(SYNC_STAGES), .RISING(TRIG_RISING)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .raw       (trig_in),
      .edge_seen (trig_edge)
   );

   adc_conv_ctrl #(
      .NORM_LEN  (NORM_LEN),
      .FIRST_LEN (FIRST_LEN),
      .NORM_SH   (NORM_SH),
      .FIRST_SH  (FIRST_SH)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (en),
      .start_req  (start_req),
      .mode       (conv_mode_e'(mode)),
      .rise       (rise),
      .fall       (fall),
      .trig_edge  (trig_edge),
      .flag_clr   (flag_clr),
      .restart    (restart),
      .sample_stb (sample_stb),
      .result_wr  (result_wr),
      .irq_flag   (irq_flag),
      .start_bit  (start_bit)
   );

   assign adc_clk_en = rise;

endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       en,
   input logic [1:0] mode,
   input logic       flag_clr,
   input logic       adc_clk_en,
   input logic       sample_stb,
   input logic       result_wr,
   input logic       irq_flag,
   input logic       start_bit
);
   a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (!adc_clk_en && !sample_stb && !result_wr));

   a_r6_write_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      result_wr |-> adc_clk_en);

   a_r4_sample_off_tick: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |-> !adc_clk_en);

   a_r6_flag_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      result_wr |=> irq_flag);

   a_r6_single_clears_start: assert property (@(posedge clk) disable iff (!rst_n)
      (result_wr && mode != 2'd1) |=> !start_bit);

   a_r9_free_keeps_start: assert property (@(posedge clk) disable iff (!rst_n)
      (result_wr && mode == 2'd1 && start_bit && en) |=> start_bit);

   a_r7_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag && !flag_clr) |=> irq_flag);
endmodule

bind adc_conv_seq adc_conv_seq_chk u_chk (.*);

// File: tb/sim_adc_conv_seq.sv
`timescale 1ns/1ps
module sim_adc_conv_seq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic       start_req = 1'b0;
   logic [1:0] mode = 2'd0;
   logic [2:0] prescale_sel = 3'd0;
   logic       trig_in = 1'b0;
   logic       flag_clr = 1'b0;
   logic       adc_clk_en, sample_stb, result_wr, irq_flag, start_bit;

   int n_chk = 0;
   int n_bad = 0;
   int ncnt  = 0;
   int stub_word = 0;

   always #2.5 clk = ~clk;

   adc_conv_seq u0 (
      .clk(clk), .rst_n(rst_n), .en(en), .start_req(start_req), .mode(mode),
      .prescale_sel(prescale_sel), .trig_in(trig_in), .flag_clr(flag_clr),
      .adc_clk_en(adc_clk_en), .sample_stb(sample_stb), .result_wr(result_wr),
      .irq_flag(irq_flag), .start_bit(start_bit)
   );

   // result source stub: supplies a fresh word at every capture strobe
   always @(posedge clk) if (result_wr) stub_word <= stub_word + 1;

   task automatic step();
      @(negedge clk);
      ncnt++;
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // 0 = tick, 1 = sample, 2 = result; checks the current cycle first
   task automatic wait_for(input int which, output int at);
      int guard = 0;
      forever begin
         if ((which == 0 && adc_clk_en) || (which == 1 && sample_stb) ||
             (which == 2 && result_wr)) break;
         step();
         guard++;
         if (guard > 5000) break;
      end
      at = ncnt;
   endtask

   task automatic quiet_window(input string req, input int len);
      int seen = 0;
      for (int i = 0; i < len; i++) begin
         step();
         if (sample_stb || result_wr) seen++;
      end
      chk(req, "strobes in idle window", seen, 0);
   endtask

   initial begin
      #(150000 * 5.0);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired: actual %0d cycles expected completion", ncnt);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int a, b, t0, ts, tr, r1, r2, r3, treq, tt, d, words;
      repeat (3) step();
      // R1: reset state
      chk("R1", "tick in reset", int'(adc_clk_en), 0);
      chk("R1", "irq in reset", int'(irq_flag), 0);
      chk("R1", "start bit in reset", int'(start_bit), 0);
      rst_n = 1'b1;
      step();

      for (int s = 0; s < 8; s++) begin
         d = (s == 0) ? 2 : (1 << s);
         en = 1'b0; mode = 2'd0; prescale_sel = 3'(s);
         begin
            int ticks = 0;
            for (int i = 0; i < 4; i++) begin step(); if (adc_clk_en) ticks++; end
            chk("R1", "ticks while disabled", ticks, 0);
         end
         en = 1'b1;
         step();
         wait_for(0, a); step(); wait_for(0, b);
         chk("R2", $sformatf("tick period sel %0d", s), b - a, d);
         step();
         // first conversion after enable (R5), software start (R3)
         start_req = 1'b1; treq = ncnt;
         step();
         start_req = 1'b0;
         chk("R3", "start bit after request", int'(start_bit), 1);
         wait_for(0, t0);
         chk("R3", "start within one divider period", int'(t0 > treq && t0 <= treq + d), 1);
         step();
         wait_for(1, ts);
         chk("R5", $sformatf("first sample delay sel %0d", s), ts - t0, 13 * d + d / 2);
         step();
         // R8: request during a running conversion
         start_req = 1'b1; step(); start_req = 1'b0;
         wait_for(2, tr);
         chk("R5", $sformatf("first result delay sel %0d", s), tr - t0, 25 * d);
         chk("R6", "write coincides with tick", int'(adc_clk_en), 1);
         step();
         chk("R6", "irq after completion", int'(irq_flag), 1);
         chk("R6", "single mode clears start", int'(start_bit), 0);
         chk("R6", "write is one cycle", int'(result_wr), 0);
         quiet_window("R8", 20 * d);
         chk("R8", "start bit after ignored request", int'(start_bit), 0);
         chk("R7", "irq sticky", int'(irq_flag), 1);
         flag_clr = 1'b1; step(); flag_clr = 1'b0;
         chk("R7", "irq cleared", int'(irq_flag), 0);
         // ordinary conversion (R4)
         start_req = 1'b1; step(); start_req = 1'b0;
         wait_for(0, t0); step();
         wait_for(1, ts);
         chk("R4", $sformatf("sample delay sel %0d", s), ts - t0, d + d / 2);
         step();
         wait_for(2, tr);
         chk("R4", $sformatf("result delay sel %0d", s), tr - t0, 13 * d);
         // R7: clear and completion together, set wins
         flag_clr = 1'b1; step(); flag_clr = 1'b0;
         chk("R7", "set wins over clear", int'(irq_flag), 1);
         flag_clr = 1'b1; step(); flag_clr = 1'b0;
      end

      // free running (R9), D = 4
      d = 4;
      en = 1'b0; step();
      prescale_sel = 3'd2; mode = 2'd1; en = 1'b1;
      words = stub_word;
      start_req = 1'b1; step(); start_req = 1'b0;
      wait_for(0, t0); step();
      wait_for(2, r1); step();
      chk("R9", "start bit held", int'(start_bit), 1);
      wait_for(2, r2); step();
      wait_for(2, r3); step();
      chk("R9", "first completion", r1 - t0, 25 * d);
      chk("R9", "back-to-back spacing", r2 - r1, 13 * d);
      chk("R9", "back-to-back spacing 2", r3 - r2, 13 * d);
      chk("R9", "start bit still held", int'(start_bit), 1);
      chk("R9", "result words captured", stub_word - words, 3);
      en = 1'b0; step();
      chk("R1", "disable clears start bit", int'(start_bit), 0);

      // trigger mode (R10, R11) at D = 2 and D = 8
      for (int k = 0; k < 2; k++) begin
         d = (k == 0) ? 2 : 8;
         en = 1'b0; trig_in = 1'b0; step();
         prescale_sel = (k == 0) ? 3'd1 : 3'd3; mode = 2'd2; en = 1'b1;
         repeat (5 + k) step();
         trig_in = 1'b1; tt = ncnt;
         step();
         wait_for(1, ts);
         chk("R10", $sformatf("first trigger sample D %0d", d), ts - tt, 2 + 13 * d + d / 2);
         trig_in = 1'b0; repeat (3) step();
         trig_in = 1'b1;
         wait_for(2, tr);
         chk("R11", $sformatf("completion unmoved by trigger D %0d", d), tr - tt, 2 + 25 * d);
         quiet_window("R11", 20 * d);
         trig_in = 1'b0; repeat (4 + 3 * k) step();
         trig_in = 1'b1; tt = ncnt;
         step();
         wait_for(1, ts);
         chk("R10", $sformatf("trigger sample D %0d", d), ts - tt, 2 + d + d / 2);
         step();
         wait_for(2, tr);
         chk("R10", $sformatf("trigger result D %0d", d), tr - tt, 2 + 13 * d);
         trig_in = 1'b0;
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule